// File: doc/BRIEF.md
# Boundary-Scan Wrapped Two-Byte Bus Driver

This block is a non-inverting driver with two independent 9-bit sides, A and B. Each side has a pair of active-low enable pins. A side drives its input data onto its output only while both of its enable pins are low. Each output is modelled as a data vector plus an active-high drive-enable that stands for the three-state control.

A 42-cell boundary-scan register wraps the driver. Observe-only cells sit on every input and enable pin. Controlling cells sit on every output bit and on each side's internal combined enable. Because the internal enables have their own controlling cells, test logic can override the enable decision without touching the enable pins.

An external TAP controller and instruction decoder supply the capture, shift and update strobes. They also supply a pair of mode selects, which the block latches on an instruction-update strobe: test control (used for EXTEST and CLAMP) and a high-impedance override. Serial data enters at `tdi` and leaves at `sdo`.

Top module: `bscan_bus_driver`

## Requirements
- R1: With test control off and no high-impedance override, `a_dout` equals `a_din` and `b_dout` equals `b_din`. `a_drive` is 1 only when both bits of `a_en_n` are 0, and the same rule links `b_drive` to `b_en_n`.
- R2: The scan register is 42 cells long and `sdo` shows cell 0. On a rising `tck` edge with `shift_dr` high and `capture_dr` low, every cell takes the value of the cell above it, and cell 41 takes `tdi`.
- R3: On a rising `tck` edge with `capture_dr` high, each cell loads its system value. The map is:
  - cell 41 = `a_en_n[0]`, cell 40 = `a_en_n[1]`, cell 39 = A internal enable;
  - cell 38 = `b_en_n[0]`, cell 37 = `b_en_n[1]`, cell 36 = B internal enable;
  - cell 35-k = `a_din[k]`, cell 26-k = `b_din[k]`;
  - cell 17-k = `a_dout[k]`, cell 8-k = `b_dout[k]`.
  
  Capture takes priority over shift.
- R4: The controlling cells are 0 to 17, 36 and 39. Each one copies its shift cell into an update latch on a falling `tck` edge with `update_dr` high, and holds that latch at all other times. Outputs driven from the latches therefore change on the falling edge.
- R5: With test control on, `a_dout[k]` comes from the latch of cell 17-k and `b_dout[k]` from the latch of cell 8-k. The internal enables come from the latches of cells 39 (A) and 36 (B), where 1 enables the side. The enable pins have no effect.
- R6: With the high-impedance override on, `a_drive` and `b_drive` are both 0, whatever the latches or pins hold.
- R7: The mode flags (test control from `ctrl_sel`, override from `hiz_sel`) load on a falling `tck` edge with `update_ir` high. `test_reset` on a falling edge clears both flags and wins over `update_ir`.
- R8: Asserting `trst_n` low clears the scan register, the update latches and the mode flags at once, without a clock edge. Its release takes effect two rising `tck` edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; shift on rising edge, update on falling edge |
| trst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial scan input into cell 41 |
| capture_dr | input | 1 | Load system values into the scan cells |
| shift_dr | input | 1 | Shift the scan register toward `sdo` |
| update_dr | input | 1 | Copy controlling cells into their update latches |
| update_ir | input | 1 | Load the mode flags from `ctrl_sel` and `hiz_sel` |
| ctrl_sel | input | 1 | Requested test-control mode |
| hiz_sel | input | 1 | Requested high-impedance override |
| test_reset | input | 1 | Synchronous clear of the mode flags |
| a_din | input | 9 | Side A data inputs |
| a_en_n | input | 2 | Side A active-low enable pins |
| b_din | input | 9 | Side B data inputs |
| b_en_n | input | 2 | Side B active-low enable pins |
| a_dout | output | 9 | Side A output data |
| a_drive | output | 1 | Side A drive-enable (0 = high impedance) |
| b_dout | output | 9 | Side B output data |
| b_drive | output | 1 | Side B drive-enable (0 = high impedance) |
| sdo | output | 1 | Serial scan output (cell 0) |

## Verification
The assertions take for granted that the external controller never raises `update_dr` and `update_ir` in the same half-cycle as a changing shift, and that strobes change only while `tck` is low. The bench meets this by moving every input one nanosecond after a falling edge. It raises at most one of capture, shift or update per step, and sets the mode selects before pulsing `update_ir`. The only exception is one deliberate case: `update_ir` and `test_reset` are raised together to check which one wins.

// File: rtl/bscan_drv_pkg.sv
package bscan_drv_pkg;

  typedef struct packed {
    logic ctrl;
    logic hiz;
  } test_mode_t;

  function automatic int chain_len(input int w);
    return 4 * w + 6;
  endfunction

  function automatic int b_int_idx(input int w);
    return 4 * w;
  endfunction

  function automatic int a_int_idx(input int w);
    return 4 * w + 3;
  endfunction

endpackage

// File: rtl/bscan_rst_sync.sv
module bscan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bscan_obs_cell.sv
module bscan_obs_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic shift,
  input  logic sys_in,
  input  logic ser_in,
  output logic cap_q
);
  logic cap_d;

  always_comb begin
    cap_d = cap_q;
    if (capture)    cap_d = sys_in;
    else if (shift) cap_d = ser_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= 1'b0;
    else        cap_q <= cap_d;
  end

  assert_obs_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> cap_q == $past(sys_in));
  assert_obs_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !capture) |=> cap_q == $past(ser_in));
endmodule

// File: rtl/bscan_ctl_cell.sv
module bscan_ctl_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic sys_in,
  input  logic ser_in,
  output logic cap_q,
  output logic upd_q
);
  logic cap_d;
  logic upd_d;

  always_comb begin
    cap_d = cap_q;
    if (capture)    cap_d = sys_in;
    else if (shift) cap_d = ser_in;
  end

  always_comb begin
    upd_d = upd_q;
    if (update) upd_d = cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= 1'b0;
    else        cap_q <= cap_d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd_d;
  end

  assert_ctl_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> cap_q == $past(sys_in));
  assert_ctl_hold_R4: assert property (@(negedge clk) disable iff (!rst_n)
    !update |=> $stable(upd_q));
  assert_ctl_load_R4: assert property (@(negedge clk) disable iff (!rst_n)
    update |=> upd_q == $past(cap_q));
endmodule

// File: rtl/bscan_mode_reg.sv
module bscan_mode_reg
  import bscan_drv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       update_ir,
  input  logic       test_reset,
  input  logic       ctrl_in,
  input  logic       hiz_in,
  output test_mode_t mode_q
);
  test_mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (test_reset) begin
      mode_d = '0;
    end else if (update_ir) begin
      mode_d.ctrl = ctrl_in;
      mode_d.hiz  = hiz_in;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assert_mode_clear_R7: assert property (@(negedge clk) disable iff (!rst_n)
    test_reset |=> (mode_q == '0));
  assert_mode_hold_R7: assert property (@(negedge clk) disable iff (!rst_n)
    (!test_reset && !update_ir) |=> $stable(mode_q));
endmodule

// File: rtl/bscan_side_drv.sv
module bscan_side_drv #(
  parameter int W = 9
) (
  input  logic [W-1:0] din,
  input  logic [1:0]   en_n,
  input  logic         ctrl,
  input  logic         hiz,
  input  logic [W-1:0] upd_data,
  input  logic         upd_en,
  output logic [W-1:0] dout,
  output logic         en_int,
  output logic         drive
);
  logic en_sys;

  always_comb begin
    en_sys = ~(en_n[0] | en_n[1]);
    if (ctrl) begin
      dout   = upd_data;
      en_int = upd_en;
    end else begin
      dout   = din;
      en_int = en_sys;
    end
    drive = en_int & ~hiz;
  end
endmodule

// File: rtl/bscan_bus_driver.sv
module bscan_bus_driver
  import bscan_drv_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tdi,
  input  logic         capture_dr,
  input  logic         shift_dr,
  input  logic         update_dr,
  input  logic         update_ir,
  input  logic         ctrl_sel,
  input  logic         hiz_sel,
  input  logic         test_reset,
  input  logic [W-1:0] a_din,
  input  logic [1:0]   a_en_n,
  input  logic [W-1:0] b_din,
  input  logic [1:0]   b_en_n,
  output logic [W-1:0] a_dout,
  output logic         a_drive,
  output logic [W-1:0] b_dout,
  output logic         b_drive,
  output logic         sdo
);
  localparam int LEN = chain_len(W);
  localparam int AI  = a_int_idx(W);
  localparam int BI  = b_int_idx(W);

  logic           rst_n;
  test_mode_t     mode_q;
  logic [LEN-1:0] sys_vec;
  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] ser_in_v;
  logic [2*W-1:0] out_upd;
  logic [1:0]     en_upd;
  logic [W-1:0]   a_upd_data;
  logic [W-1:0]   b_upd_data;
  logic           a_en_int;
  logic           b_en_int;

  bscan_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(tck), .arst_n(trst_n), .rst_n(rst_n)
  );

  bscan_mode_reg u_mode (
    .clk(tck), .rst_n(rst_n), .update_ir(update_ir), .test_reset(test_reset),
    .ctrl_in(ctrl_sel), .hiz_in(hiz_sel), .mode_q(mode_q)
  );

  bscan_side_drv #(.W(W)) u_side_a (
    .din(a_din), .en_n(a_en_n), .ctrl(mode_q.ctrl), .hiz(mode_q.hiz),
    .upd_data(a_upd_data), .upd_en(en_upd[1]),
    .dout(a_dout), .en_int(a_en_int), .drive(a_drive)
  );

  bscan_side_drv #(.W(W)) u_side_b (
    .din(b_din), .en_n(b_en_n), .ctrl(mode_q.ctrl), .hiz(mode_q.hiz),
    .upd_data(b_upd_data), .upd_en(en_upd[0]),
    .dout(b_dout), .en_int(b_en_int), .drive(b_drive)
  );

  // System-side values seen by the cells, and latch fan-out to the drivers.
  for (genvar k = 0; k < W; k++) begin : g_map
    assign sys_vec[W-1-k]   = b_dout[k];
    assign sys_vec[2*W-1-k] = a_dout[k];
    assign sys_vec[3*W-1-k] = b_din[k];
    assign sys_vec[4*W-1-k] = a_din[k];
    assign a_upd_data[k]    = out_upd[2*W-1-k];
    assign b_upd_data[k]    = out_upd[W-1-k];
  end
  assign sys_vec[BI]   = b_en_int;
  assign sys_vec[BI+1] = b_en_n[1];
  assign sys_vec[BI+2] = b_en_n[0];
  assign sys_vec[AI]   = a_en_int;
  assign sys_vec[AI+1] = a_en_n[1];
  assign sys_vec[AI+2] = a_en_n[0];

  assign ser_in_v = {tdi, chain_q[LEN-1:1]};

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    if (i < 2 * W) begin : g_out
      bscan_ctl_cell u_cell (
        .clk(tck), .rst_n(rst_n), .capture(capture_dr), .shift(shift_dr),
        .update(update_dr), .sys_in(sys_vec[i]), .ser_in(ser_in_v[i]),
        .cap_q(chain_q[i]), .upd_q(out_upd[i])
      );
    end else if (i == AI) begin : g_aen
      bscan_ctl_cell u_cell (
        .clk(tck), .rst_n(rst_n), .capture(capture_dr), .shift(shift_dr),
        .update(update_dr), .sys_in(sys_vec[i]), .ser_in(ser_in_v[i]),
        .cap_q(chain_q[i]), .upd_q(en_upd[1])
      );
    end else if (i == BI) begin : g_ben
      bscan_ctl_cell u_cell (
        .clk(tck), .rst_n(rst_n), .capture(capture_dr), .shift(shift_dr),
        .update(update_dr), .sys_in(sys_vec[i]), .ser_in(ser_in_v[i]),
        .cap_q(chain_q[i]), .upd_q(en_upd[0])
      );
    end else begin : g_obs
      bscan_obs_cell u_cell (
        .clk(tck), .rst_n(rst_n), .capture(capture_dr), .shift(shift_dr),
        .sys_in(sys_vec[i]), .ser_in(ser_in_v[i]), .cap_q(chain_q[i])
      );
    end
  end

  assign sdo = chain_q[0];

  assert_hiz_off_R6: assert property (@(posedge tck) disable iff (!rst_n)
    mode_q.hiz |-> (!a_drive && !b_drive));
  assert_normal_pins_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (!mode_q.ctrl && !mode_q.hiz) |->
      (a_drive == (a_en_n == 2'b00)) && (b_drive == (b_en_n == 2'b00)) &&
      (a_dout == a_din) && (b_dout == b_din));
  assert_ctrl_latch_R5: assert property (@(posedge tck) disable iff (!rst_n)
    (mode_q.ctrl && !mode_q.hiz) |->
      (a_drive == en_upd[1]) && (b_drive == en_upd[0]));
  assert_sdo_shift_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_dr && !capture_dr) |=> sdo == $past(chain_q[1]));
endmodule

// File: tb/bscan_bus_driver_bench.sv
module bscan_bus_driver_bench;
  logic       tck, trst_n, tdi, capture_dr, shift_dr, update_dr, update_ir;
  logic       ctrl_sel, hiz_sel, test_reset;
  logic [8:0] a_din, b_din, a_dout, b_dout;
  logic [1:0] a_en_n, b_en_n;
  logic       a_drive, b_drive, sdo;

  int vectors = 0;
  int miscompares = 0;

  bscan_bus_driver u_bscan_bus_driver (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .update_ir(update_ir),
    .ctrl_sel(ctrl_sel), .hiz_sel(hiz_sel), .test_reset(test_reset),
    .a_din(a_din), .a_en_n(a_en_n), .b_din(b_din), .b_en_n(b_en_n),
    .a_dout(a_dout), .a_drive(a_drive), .b_dout(b_dout), .b_drive(b_drive),
    .sdo(sdo)
  );

  initial tck = 1'b0;
  always #4 tck = ~tck;

  // {a_din, b_din, a_en_n, b_en_n, exp a_drive, exp b_drive}
  localparam logic [23:0] VEC [6] = '{
    {9'h155, 9'h0AA, 2'b00, 2'b00, 1'b1, 1'b1},
    {9'h1FF, 9'h000, 2'b01, 2'b00, 1'b0, 1'b1},
    {9'h000, 9'h1FF, 2'b00, 2'b10, 1'b1, 1'b0},
    {9'h123, 9'h0F0, 2'b11, 2'b11, 1'b0, 1'b0},
    {9'h0C3, 9'h13C, 2'b10, 2'b01, 1'b0, 1'b0},
    {9'h001, 9'h100, 2'b00, 2'b00, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  function automatic logic [41:0] cell_vec(input logic [8:0] ad, bd, input logic [1:0] ae, be,
                                           input logic ai, bi, input logic [8:0] ao, bo);
    logic [41:0] v;
    v = '0;
    for (int k = 0; k < 9; k++) begin
      v[8-k]  = bo[k];
      v[17-k] = ao[k];
      v[26-k] = bd[k];
      v[35-k] = ad[k];
    end
    v[36] = bi; v[37] = be[1]; v[38] = be[0];
    v[39] = ai; v[40] = ae[1]; v[41] = ae[0];
    return v;
  endfunction

  task automatic scan_dr(input logic [41:0] vin, output logic [41:0] vout);
    capture_dr = 1'b1; step(); capture_dr = 1'b0;
    shift_dr = 1'b1;
    for (int i = 0; i < 42; i++) begin
      vout[i] = sdo;
      tdi = vin[i];
      step();
    end
    shift_dr = 1'b0;
  endtask

  task automatic upd_dr();
    update_dr = 1'b1; step(); update_dr = 1'b0;
  endtask

  task automatic set_mode(input logic c, input logic h);
    ctrl_sel = c; hiz_sel = h; update_ir = 1'b1; step(); update_ir = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [41:0] got, pat;
    trst_n = 1'b0; tdi = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0;
    update_dr = 1'b0; update_ir = 1'b0; ctrl_sel = 1'b0; hiz_sel = 1'b0;
    test_reset = 1'b0; a_din = '0; b_din = '0; a_en_n = 2'b11; b_en_n = 2'b11;
    step(); step();
    trst_n = 1'b1;
    step(); step(); step();

    // R8 reset state
    chk("R8 reset sdo", 64'(sdo), 64'd0);
    chk("R8 reset drives", 64'({a_drive, b_drive}), 64'd0);

    // R1 table walk in normal mode
    foreach (VEC[n]) begin
      {a_din, b_din, a_en_n, b_en_n} = VEC[n][23:2];
      step();
      chk("R1 a_drive", 64'(a_drive), 64'(VEC[n][1]));
      chk("R1 b_drive", 64'(b_drive), 64'(VEC[n][0]));
      chk("R1 data", 64'({a_dout, b_dout}), 64'({a_din, b_din}));
    end

    // R3 capture in normal mode
    a_din = 9'h0A5; b_din = 9'h11E; a_en_n = 2'b01; b_en_n = 2'b00;
    scan_dr('0, got);
    chk("R3 capture normal", 64'(got),
        64'(cell_vec(9'h0A5, 9'h11E, 2'b01, 2'b00, 1'b0, 1'b1, 9'h0A5, 9'h11E)));

    // R2 shift-only round trip
    pat = 42'h2A5_F00D_C3B1;
    shift_dr = 1'b1;
    for (int i = 0; i < 42; i++) begin tdi = pat[i]; step(); end
    for (int i = 0; i < 42; i++) begin got[i] = sdo; tdi = 1'b0; step(); end
    shift_dr = 1'b0;
    chk("R2 shift round trip", 64'(got), 64'(pat));

    // R4/R5 load latches, then enter test control with pins opposing
    a_en_n = 2'b11; b_en_n = 2'b00;
    scan_dr(cell_vec('0, '0, '0, '0, 1'b1, 1'b0, 9'h0F5, 9'h10A), got);
    upd_dr();
    set_mode(1'b1, 1'b0);
    chk("R5 a_dout latch", 64'(a_dout), 64'h0F5);
    chk("R5 b_dout latch", 64'(b_dout), 64'h10A);
    chk("R5 enables from latch", 64'({a_drive, b_drive}), 64'b10);

    // R3 capture in test control, shift new pattern; R4 outputs hold
    scan_dr(cell_vec('0, '0, '0, '0, 1'b0, 1'b1, 9'h03C, 9'h1C3), got);
    chk("R3 capture ctrl", 64'(got),
        64'(cell_vec(9'h0A5, 9'h11E, 2'b11, 2'b00, 1'b1, 1'b0, 9'h0F5, 9'h10A)));
    chk("R4 hold during shift", 64'({a_dout, b_dout, a_drive, b_drive}),
        64'({9'h0F5, 9'h10A, 2'b10}));

    // R4 update takes effect on falling edge only
    update_dr = 1'b1;
    @(posedge tck); #1;
    chk("R4 before falling edge", 64'({a_dout, a_drive}), 64'({9'h0F5, 1'b1}));
    @(negedge tck); #1;
    update_dr = 1'b0;
    chk("R4 after falling edge", 64'({a_dout, b_dout, a_drive, b_drive}),
        64'({9'h03C, 9'h1C3, 2'b01}));

    // R6 override with test control, then with normal pins enabled
    set_mode(1'b1, 1'b1);
    chk("R6 hiz in ctrl", 64'({a_drive, b_drive}), 64'd0);
    a_en_n = 2'b00; b_en_n = 2'b00;
    set_mode(1'b0, 1'b1);
    chk("R6 hiz in normal", 64'({a_drive, b_drive}), 64'd0);

    // R7 test reset returns to normal immediately and wins over update_ir
    set_mode(1'b1, 1'b0);
    a_en_n = 2'b00; b_en_n = 2'b10; a_din = 9'h18F; b_din = 9'h071;
    ctrl_sel = 1'b1; update_ir = 1'b1; test_reset = 1'b1;
    step();
    update_ir = 1'b0; test_reset = 1'b0;
    chk("R7 test reset drives", 64'({a_drive, b_drive}), 64'b10);
    chk("R7 test reset data", 64'({a_dout, b_dout}), 64'({9'h18F, 9'h071}));

    // R8 asynchronous reset mid-run
    set_mode(1'b1, 1'b1);
    trst_n = 1'b0; #1;
    chk("R8 async mode clear", 64'({a_drive, b_drive, a_dout}), 64'({2'b10, 9'h18F}));
    chk("R8 async sdo", 64'(sdo), 64'd0);
    step(); trst_n = 1'b1; step(); step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule